// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a supervision timer that software programs through a small register write port. In watchdog mode it counts down a first interval and raises a one-cycle interrupt when that interval runs out. It then counts down a second interval, and when that one also runs out it pulls an active-low timeout line and holds it there. Software stops this from happening by restarting the count before the intervals run out. A restart and any change to the two interval values are honoured only after a two-write key sequence.

In free-running mode the block skips the first interval. It behaves as a periodic tick source that uses only the second interval: it reloads itself and pulses the interrupt each time the count runs out. A control register holds the mode and the enable bit. It also holds a sticky lock bit that freezes the control register until a hard reset. An external prescaler tick paces all counting.

Top module: `wdog_top`

## Requirements
- R1: After reset `irq` is 0, `toutN` is 1, and the control register is cleared: disabled, unlocked, watchdog mode. Ticks then have no effect.
- R2: The control register is at address 3. Bit 1 is the enable and bit 2 is the mode (0 = watchdog, 1 = free-running). An accepted control write that leaves the enable at 1 starts counting from a fresh load: stage one in watchdog mode, stage two in free-running mode.
- R3: The counter changes only on a cycle where `tick` is 1. A stage that was loaded with value P runs out on the (P+1)th tick after the load. A stage event appears on the outputs one cycle after that tick.
- R4: In watchdog mode, stage one (preload one, written at address 0) ends with a single-cycle `irq` pulse. Stage two then loads from preload two, which is written at address 1.
- R5: In watchdog mode the end of stage two drives `toutN` to 0. It stays 0, with no further `irq`, until a restart, a disable or a reset.
- R6: In free-running mode only preload two is used. `irq` pulses every P2+1 ticks, the counter reloads itself, and `toutN` never goes low.
- R7: Unlock register at address 2: a write of 0x80 followed directly by a write of 0x86 opens the protected writes. Any other write between them aborts the sequence. An opened sequence admits exactly one protected write.
- R8: The protected writes are preload one, preload two and restart (any data written to address 4). When no sequence is open, each of them is ignored.
- R9: An accepted restart releases `toutN` and begins counting again from stage one (stage two in free-running mode).
- R10: Writing the enable bit to 0 stops counting, releases `toutN` and suppresses `irq`.
- R11: Bit 0 of the control register is the lock. Once it is set, writes to the control register are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | CNT_W (16) | Write data |
| tick | input | 1 | Prescaler tick, one cycle wide |
| irq | output | 1 | Single-cycle interrupt pulse at a stage-one or free-running expiry |
| toutN | output | 1 | Active-low timeout, held low after a stage-two expiry in watchdog mode |

## Verification
The assertions assume that a write is a single-cycle `wrEn` pulse and that `tick` comes only while no restart is pending. The bench drives each write for exactly one cycle and then leaves an idle cycle, so the registered restart has landed before the next tick. It spaces ticks two cycles apart, which keeps every `irq` pulse isolated, and it samples outputs on the falling edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PRE1   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE2   = 3'd1;
  localparam logic [ADDR_W-1:0] A_UNLOCK = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;

  localparam logic [7:0] KEY_ARM  = 8'h80;
  localparam logic [7:0] KEY_OPEN = 8'h86;

  localparam int CB_LOCK = 0;
  localparam int CB_EN   = 1;
  localparam int CB_MODE = 2;
  localparam int CTRL_W  = 3;

  typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} unlockE;
  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO, ST_DONE} stageE;

  typedef struct packed {
    logic wrPre1;
    logic wrPre2;
    logic restart;
    logic enable;
    logic freeRun;
  } wdStrobeT;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  output wdStrobeT          strb
);
  localparam logic [DW-1:0] ARM_W  = DW'(KEY_ARM);
  localparam logic [DW-1:0] OPEN_W = DW'(KEY_OPEN);

  unlockE ulState, ulNext;
  logic [CTRL_W-1:0] ctrlQ;
  logic restartQ;
  logic isProt, protOk, ctrlWrOk, isUnlock;

  assign isUnlock = wrEn && (wrAddr == A_UNLOCK);
  assign isProt   = wrEn && ((wrAddr == A_PRE1) || (wrAddr == A_PRE2) || (wrAddr == A_RELOAD));
  assign protOk   = isProt && (ulState == UL_OPEN);
  assign ctrlWrOk = wrEn && (wrAddr == A_CTRL) && !ctrlQ[CB_LOCK];

  always_comb begin
    ulNext = ulState;
    if (isUnlock) begin
      if (wrData == ARM_W)                                ulNext = UL_ARMED;
      else if (wrData == OPEN_W && ulState == UL_ARMED)   ulNext = UL_OPEN;
      else                                                ulNext = UL_IDLE;
    end else if (wrEn) begin
      ulNext = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ulState  <= UL_IDLE;
      ctrlQ    <= '0;
      restartQ <= 1'b0;
    end else begin
      ulState  <= ulNext;
      if (ctrlWrOk) ctrlQ <= wrData[CTRL_W-1:0];
      restartQ <= (protOk && wrAddr == A_RELOAD) || (ctrlWrOk && wrData[CB_EN]);
    end
  end

  assign strb.wrPre1  = protOk && (wrAddr == A_PRE1);
  assign strb.wrPre2  = protOk && (wrAddr == A_PRE2);
  assign strb.restart = restartQ;
  assign strb.enable  = ctrlQ[CB_EN];
  assign strb.freeRun = ctrlQ[CB_MODE];

  p_one_shot_r7: assert property (@(posedge clk) disable iff (!rstN)
    protOk |=> (ulState != UL_OPEN));
  p_no_open_skip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ulState == UL_OPEN) |-> ($past(ulState) == UL_ARMED || $past(ulState) == UL_OPEN));
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[CB_LOCK] |=> ctrlQ[CB_LOCK]);
  p_ctrl_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[CB_LOCK] |=> $stable(ctrlQ));
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] wrData,
  input  wdStrobeT         strb,
  output logic             irq,
  output logic             toutN
);
  logic [CNT_W-1:0] pre1Q, pre2Q, cntQ;
  stageE stage;
  logic  atZero;

  assign atZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre1Q <= '1;
      pre2Q <= '1;
    end else begin
      if (strb.wrPre1) pre1Q <= wrData;
      if (strb.wrPre2) pre2Q <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= ST_IDLE;
      cntQ  <= '0;
      irq   <= 1'b0;
      toutN <= 1'b1;
    end else begin
      irq <= 1'b0;
      if (!strb.enable) begin
        stage <= ST_IDLE;
        toutN <= 1'b1;
      end else if (strb.restart) begin
        toutN <= 1'b1;
        if (strb.freeRun) begin
          stage <= ST_TWO;
          cntQ  <= pre2Q;
        end else begin
          stage <= ST_ONE;
          cntQ  <= pre1Q;
        end
      end else if (tick) begin
        unique case (stage)
          ST_ONE: begin
            if (atZero) begin
              irq   <= 1'b1;
              stage <= ST_TWO;
              cntQ  <= pre2Q;
            end else cntQ <= cntQ - 1'b1;
          end
          ST_TWO: begin
            if (atZero) begin
              if (strb.freeRun) begin
                irq  <= 1'b1;
                cntQ <= pre2Q;
              end else begin
                toutN <= 1'b0;
                stage <= ST_DONE;
              end
            end else cntQ <= cntQ - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_irq_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(tick));
  p_tout_fall_wd_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toutN) |-> !strb.freeRun);
  p_tout_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!toutN && strb.enable && !strb.restart) |=> (!toutN && !irq));
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enable |=> (!irq && toutN));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             tick,
  output logic             irq,
  output logic             toutN
);
  wdStrobeT strb;

  wdog_ctrl #(.DW(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strb(strb)
  );

  wdog_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .wrData(wrData),
    .strb(strb), .irq(irq), .toutN(toutN)
  );
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, tick = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic irq, toutN;
  int nTests = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_top #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tick(tick), .irq(irq), .toutN(toutN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(3'd2, 16'h0080);
    wr(3'd2, 16'h0086);
  endtask

  task automatic runTicks(input int n, output int irqCnt, output int lastIrq, output int toutAt);
    irqCnt = 0; lastIrq = 0; toutAt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (irq) begin irqCnt++; lastIrq = i; end
      if (!toutN && toutAt == 0) toutAt = i;
    end
  endtask

  task automatic testReset();
    int c, l, t;
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(toutN == 1'b1, "R1 toutN", toutN, 1);
    runTicks(5, c, l, t);
    check(c == 0 && t == 0, "R1 idle ticks", c + t, 0);
  endtask

  task automatic testWatchdog();
    int c, l, t;
    unlock(); wr(3'd0, 16'd3);
    unlock(); wr(3'd1, 16'd2);
    wr(3'd3, 16'b010);
    runTicks(3, c, l, t);
    check(c == 0, "R2 R3 no early irq", c, 0);
    runTicks(1, c, l, t);
    check(c == 1, "R4 stage one irq", c, 1);
    runTicks(2, c, l, t);
    check(c == 0 && t == 0, "R4 stage two running", t, 0);
    runTicks(1, c, l, t);
    check(t == 1, "R5 timeout at stage two end", t, 1);
    runTicks(4, c, l, t);
    check(c == 0 && toutN == 1'b0, "R5 timeout held", toutN, 0);
  endtask

  task automatic testReload();
    int c, l, t;
    wr(3'd4, 16'd0);
    check(toutN == 1'b0, "R8 reload without key ignored", toutN, 0);
    unlock(); wr(3'd4, 16'd0);
    check(toutN == 1'b1, "R9 reload releases toutN", toutN, 1);
    runTicks(4, c, l, t);
    check(c == 1 && l == 4, "R9 restart from stage one", l, 4);
    runTicks(3, c, l, t);
    check(t == 3, "R9 stage two after restart", t, 3);
    wr(3'd2, 16'h0080); wr(3'd7, 16'd0); wr(3'd2, 16'h0086);
    wr(3'd4, 16'd0);
    check(toutN == 1'b0, "R7 aborted sequence blocks reload", toutN, 0);
  endtask

  task automatic testOneShot();
    int c, l, t;
    unlock(); wr(3'd0, 16'd1);
    wr(3'd1, 16'd5);
    unlock(); wr(3'd4, 16'd0);
    check(toutN == 1'b1, "R7 reload after fresh key", toutN, 1);
    runTicks(8, c, l, t);
    check(c == 1 && l == 2, "R7 preload one taken", l, 2);
    check(t == 5, "R8 second preload write ignored", t, 5);
  endtask

  task automatic testDisable();
    int c, l, t;
    wr(3'd3, 16'b000);
    check(toutN == 1'b1, "R10 disable releases toutN", toutN, 1);
    runTicks(6, c, l, t);
    check(c == 0 && t == 0, "R10 no activity disabled", c + t, 0);
  endtask

  task automatic testFreeRun();
    int c, l, t;
    wr(3'd3, 16'b110);
    runTicks(9, c, l, t);
    check(c == 3, "R6 periodic irq count", c, 3);
    check(l == 9, "R6 last irq tick", l, 9);
    check(t == 0, "R6 no timeout", t, 0);
  endtask

  task automatic testLock();
    int c, l, t;
    wr(3'd3, 16'b111);
    runTicks(3, c, l, t);
    check(c == 1 && l == 3, "R2 free restart on control write", l, 3);
    wr(3'd3, 16'b000);
    runTicks(3, c, l, t);
    check(c == 1 && l == 3, "R11 disable ignored when locked", c, 1);
    wr(3'd3, 16'b010);
    runTicks(12, c, l, t);
    check(c == 4 && t == 0, "R11 mode change ignored when locked", c, 4);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testWatchdog();
        testReload();
        testOneShot();
        testDisable();
        testFreeRun();
        testLock();
      end
      begin
        repeat (20000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule